// File: doc/BRIEF.md
# Sixteen-Bit Timer with Two Compare Channels and Force Strobes

This block is a 16-bit up-counter with two compare channels, A and B, programmed over an 8-bit register bus. The counter steps on a clock-enable input that stands in for a prescaler, or on edges of an external count pin, which first crosses a synchronizer. Each channel compares its own 16-bit compare value with the counter. On a match it raises a flag and updates a waveform pin as set by a 2-bit action code. The waveform setting picks free-running counting or clear-on-match, where channel A's value is the top of the count. Two further codes are reserved for pulse-width modes. They count freely, but force strobes have no effect in them.

Software moves a 16-bit quantity as two bytes through one staging byte that all 16-bit registers share, so both halves land or are sampled on the same edge. A force strobe drives a channel's pin as if a match had occurred. It does not touch the flag or the counter. After software writes the counter, the match on the next counter step is dropped on both channels.

Top module: `tmr_cmp_top`

Register addresses (`addr`): 0 configuration, 1 force/flag, 2 counter low, 3 counter high, 4 compare A low, 5 compare A high, 6 compare B low, 7 compare B high. Configuration bits: [1:0] channel A action, [3:2] channel B action, [5:4] waveform (00 free-running, 01 clear-on-match with A as top, 10 and 11 pulse-width codes), [6] count source (1 = external pin), [7] edge polarity (1 = rising, 0 = falling).

## Requirements
- R1: After reset the counter, both compare values, the configuration byte, both flags and both pins read as zero.
- R2: Writing a high-byte address (3, 5, 7) only loads the staging byte. Writing the paired low address loads {staging byte, written byte} into the 16-bit register on that edge, and a read of the 16-bit register returns what was written.
- R3: Reading a low-byte address (2, 4, 6) returns the low byte and copies that register's high byte into the staging byte. A later read of any high address returns that copy even if the counter has moved since.
- R4: The staging byte is shared: a high byte written at one register's address is used by a low-byte write to a different register.
- R5: With waveform 00 the counter rises by one per step and wraps from 0xFFFF to 0x0000.
- R6: With waveform 01, a step in which the counter equals compare A sets the counter to zero, so the count runs 0 to compare A.
- R7: A step in which the counter equals a channel's compare value sets that channel's flag. Writing 1 to bit 0 (A) or bit 1 (B) of address 1 clears it.
- R8: On a match the action code acts on the channel's pin state: 01 toggles, 10 clears, 11 sets, 00 leaves it. The pin reads 0 while the code is 00, and the held state comes back when a code other than 00 is restored.
- R9: Writing 1 to bit 7 (A) or bit 6 (B) of address 1 applies that channel's current action to its pin on that edge. It sets no flag and leaves the counter unchanged, in waveform 01 as well.
- R10: With waveform 10 or 11 the force bits have no effect on the pins.
- R11: Bits 7 and 6 of address 1 always read zero. Bits 1:0 read the flags B and A.
- R12: After a counter write, the next step produces no match on either channel: no flag, no pin action, no clear-on-match.
- R13: With count source 1 the counter ignores the clock enable and steps once per selected edge of the external pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Prescaled count enable |
| extPin | input | 1 | External count pin, asynchronous |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from addr |
| ocA | output | 1 | Channel A waveform pin |
| ocB | output | 1 | Channel B waveform pin |
| flagA | output | 1 | Channel A match flag |
| flagB | output | 1 | Channel B match flag |

## Verification
The bench builds the block with its default synchronizer depth of two stages. An external edge therefore reaches the counter three clocks after the pin moves, and the pin is held for four clocks per level. The full 16-bit width is kept. The wrap and the suppressed match are reached by loading the counter just below the point of interest, not by counting there. Random 16-bit values pass through all three registers to exercise the staging byte across addresses.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NCH    = 2;

  typedef enum logic [2:0] {
    ADR_CFG   = 3'd0,
    ADR_FRC   = 3'd1,
    ADR_CNT_L = 3'd2,
    ADR_CNT_H = 3'd3,
    ADR_CA_L  = 3'd4,
    ADR_CA_H  = 3'd5,
    ADR_CB_L  = 3'd6,
    ADR_CB_H  = 3'd7
  } addr_e;

  typedef enum logic [1:0] {
    COM_OFF = 2'b00,
    COM_TGL = 2'b01,
    COM_CLR = 2'b10,
    COM_SET = 2'b11
  } com_e;

  typedef enum logic [1:0] {
    WAV_FREE = 2'b00,
    WAV_CTC  = 2'b01,
    WAV_PW0  = 2'b10,
    WAV_PW1  = 2'b11
  } wave_e;

  typedef struct packed {
    logic  edgeRise;
    logic  extSel;
    wave_e wave;
    com_e  comB;
    com_e  comA;
  } cfg_t;

  typedef struct packed {
    logic             loadCnt;
    logic             loadCmpA;
    logic             loadCmpB;
    logic [CNT_W-1:0] loadVal;
    logic             forceA;
    logic             forceB;
    logic             clrA;
    logic             clrB;
  } strobe_t;
endpackage

// File: rtl/tmr_cmp_ctrl.sv
module tmr_cmp_ctrl
  import tmr_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmpA,
  input  logic [CNT_W-1:0]  cmpB,
  input  logic [NCH-1:0]    flags,
  output cfg_t              cfg,
  output strobe_t           stb,
  output logic [BYTE_W-1:0] rdData
);
  logic [BYTE_W-1:0] tempHi;
  logic [CNT_W-1:0]  selVal;
  logic              pwmWave;
  addr_e             adr;

  assign adr     = addr_e'(addr);
  assign pwmWave = cfg.wave[1];

  always_comb begin
    case (adr)
      ADR_CA_L, ADR_CA_H: selVal = cmpA;
      ADR_CB_L, ADR_CB_H: selVal = cmpB;
      default:            selVal = cnt;
    endcase
  end

  always_comb begin
    stb = '0;
    stb.loadVal = {tempHi, wrData};
    if (wrEn) begin
      case (adr)
        ADR_FRC: begin
          stb.forceA = wrData[7] & ~pwmWave;
          stb.forceB = wrData[6] & ~pwmWave;
          stb.clrA   = wrData[0];
          stb.clrB   = wrData[1];
        end
        ADR_CNT_L: stb.loadCnt  = 1'b1;
        ADR_CA_L:  stb.loadCmpA = 1'b1;
        ADR_CB_L:  stb.loadCmpB = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg    <= '0;
      tempHi <= '0;
    end else begin
      if (wrEn && adr == ADR_CFG) cfg <= cfg_t'(wrData);
      if (wrEn && addr[0] && addr[2:1] != 2'b00)
        tempHi <= wrData;
      else if (rdEn && !wrEn && !addr[0] && addr[2:1] != 2'b00)
        tempHi <= selVal[CNT_W-1:BYTE_W];
    end
  end

  always_comb begin
    case (adr)
      ADR_CFG: rdData = cfg;
      ADR_FRC: rdData = {{(BYTE_W-NCH){1'b0}}, flags};
      ADR_CNT_L, ADR_CA_L, ADR_CB_L: rdData = selVal[BYTE_W-1:0];
      default: rdData = tempHi;
    endcase
  end
endmodule

// File: rtl/tmr_cmp_dp.sv
module tmr_cmp_dp
  import tmr_cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             extPin,
  input  cfg_t             cfg,
  input  strobe_t          stb,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmpA,
  output logic [CNT_W-1:0] cmpB,
  output logic [NCH-1:0]   flags,
  output logic [NCH-1:0]   ocPin
);
  localparam int SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SS-1:0]    syncQ;
  logic             prevLvl;
  logic             extEdge;
  logic             step;
  logic             blockArm;
  logic [CNT_W-1:0] cmpQ [NCH];
  logic [NCH-1:0]   hit;
  logic [NCH-1:0]   ocQ;
  logic [NCH-1:0]   loadCmp;
  logic [NCH-1:0]   forceV;
  logic [NCH-1:0]   clrV;
  com_e             comSel [NCH];

  assign loadCmp   = {stb.loadCmpB, stb.loadCmpA};
  assign forceV    = {stb.forceB, stb.forceA};
  assign clrV      = {stb.clrB, stb.clrA};
  assign comSel[0] = cfg.comA;
  assign comSel[1] = cfg.comB;

  // external count pin: synchronizer, then edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SS-2:0], extPin};
      prevLvl <= syncQ[SS-1];
    end
  end

  assign extEdge = cfg.edgeRise ? (syncQ[SS-1] & ~prevLvl)
                                : (~syncQ[SS-1] & prevLvl);
  assign step    = cfg.extSel ? extEdge : tickEn;

  // a CPU counter write suppresses matches on the next step
  always_ff @(posedge clk) begin
    if (!rstN)            blockArm <= 1'b0;
    else if (stb.loadCnt) blockArm <= 1'b1;
    else if (step)        blockArm <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (stb.loadCnt) cnt <= stb.loadVal;
    else if (step)        cnt <= (cfg.wave == WAV_CTC && hit[0]) ? '0 : cnt + 1'b1;
  end

  function automatic logic nextPin(com_e mode, logic cur);
    case (mode)
      COM_TGL: return ~cur;
      COM_CLR: return 1'b0;
      COM_SET: return 1'b1;
      default: return cur;
    endcase
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = step && !blockArm && (cnt == cmpQ[i]);

    always_ff @(posedge clk) begin
      if (!rstN)           cmpQ[i] <= '0;
      else if (loadCmp[i]) cmpQ[i] <= stb.loadVal;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                    ocQ[i] <= 1'b0;
      else if (hit[i] || forceV[i]) ocQ[i] <= nextPin(comSel[i], ocQ[i]);
    end

    always_ff @(posedge clk) begin
      if (!rstN)        flags[i] <= 1'b0;
      else if (hit[i])  flags[i] <= 1'b1;
      else if (clrV[i]) flags[i] <= 1'b0;
    end

    assign ocPin[i] = (comSel[i] != COM_OFF) & ocQ[i];

    p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[i]) |-> $past(step && !blockArm && cnt == cmpQ[i]));

    p_force_noflag_r9: assert property (@(posedge clk) disable iff (!rstN)
      forceV[i] && !step && !flags[i] |=> !flags[i]);

    p_block_match_r12: assert property (@(posedge clk) disable iff (!rstN)
      blockArm && step && !flags[i] |=> !flags[i]);
  end

  assign cmpA = cmpQ[0];
  assign cmpB = cmpQ[1];

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !step && !stb.loadCnt |=> $stable(cnt));

  p_ctc_top_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfg.wave == WAV_CTC && step && !blockArm && cnt == cmpQ[0] && !stb.loadCnt
    |=> cnt == '0);

  p_ext_only_r13: assert property (@(posedge clk) disable iff (!rstN)
    cfg.extSel && !extEdge && !stb.loadCnt |=> $stable(cnt));
endmodule

// File: rtl/tmr_cmp_top.sv
module tmr_cmp_top
  import tmr_cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       extPin,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       ocA,
  output logic       ocB,
  output logic       flagA,
  output logic       flagB
);
  cfg_t             cfg;
  strobe_t          stb;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmpA;
  logic [CNT_W-1:0] cmpB;
  logic [NCH-1:0]   flags;
  logic [NCH-1:0]   ocPin;

  tmr_cmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cnt(cnt), .cmpA(cmpA), .cmpB(cmpB), .flags(flags),
    .cfg(cfg), .stb(stb), .rdData(rdData)
  );

  tmr_cmp_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extPin(extPin), .cfg(cfg),
    .stb(stb), .cnt(cnt), .cmpA(cmpA), .cmpB(cmpB), .flags(flags),
    .ocPin(ocPin)
  );

  assign ocA   = ocPin[0];
  assign ocB   = ocPin[1];
  assign flagA = flags[0];
  assign flagB = flags[1];

  p_force_pwm_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == 3'd1 && cfg.wave[1] && !tickEn && !cfg.extSel
    |=> $stable(ocA) && $stable(ocB));

  always_comb begin
    if (rstN === 1'b1 && addr == 3'd1)
      p_force_reads_zero_r11: assert (rdData[7:6] == 2'b00);
  end
endmodule

// File: tb/tb_tmr_cmp_top.sv
module tb_tmr_cmp_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       extPin = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       ocA, ocB, flagA, flagB;

  int nChecks = 0;
  int nFails  = 0;

  tmr_cmp_top dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extPin(extPin), .wrEn(wrEn),
    .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .ocA(ocA), .ocB(ocB), .flagA(flagA), .flagB(flagB)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo + 3'd1, v[15:8]);
    wr(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic pulsePin(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); extPin = 1'b1;
      repeat (4) @(negedge clk);
      extPin = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  // expected contents of each 16-bit register after a write of v to target t
  function automatic logic [15:0] model16(logic [15:0] prev, int t, int tgt,
                                          logic [15:0] v);
    return (t == tgt) ? v : prev;
  endfunction

  function automatic logic [7:0] cfgByte(logic [1:0] ca, logic [1:0] cb,
                                         logic [1:0] wv, logic ext, logic rise);
    return {rise, ext, wv, cb, ca};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    logic [15:0] mdl [3];

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3'd0, b); chk("R1 cfg", b, 0);
    rd16(3'd2, v); chk("R1 counter", v, 0);
    rd16(3'd4, v); chk("R1 compare A", v, 0);
    rd16(3'd6, v); chk("R1 compare B", v, 0);
    chk("R1 pins", {ocA, ocB, flagA, flagB}, 0);

    // R2 random 16-bit values through all three registers
    void'($urandom(32'h1a2b3c4d));
    mdl[0] = 16'h0; mdl[1] = 16'h0; mdl[2] = 16'h0;
    for (int it = 0; it < 24; it++) begin
      int tgt;
      logic [15:0] rv;
      tgt = int'($urandom_range(2, 0));
      rv  = 16'($urandom);
      if (it == 0) rv = 16'hFFFF;
      if (it == 1) rv = 16'h0000;
      wr16(3'(2 + 2 * tgt), rv);
      for (int r = 0; r < 3; r++) mdl[r] = model16(mdl[r], r, tgt, rv);
      for (int r = 0; r < 3; r++) begin
        rd16(3'(2 + 2 * r), v);
        chk("R2 16-bit readback", v, mdl[r]);
      end
    end

    // R2 a lone high-byte write leaves the counter unchanged
    wr16(3'd2, 16'h1111);
    wr(3'd3, 8'h77);
    rd16(3'd2, v); chk("R2 high write alone", v, 16'h1111);

    // R4 shared staging byte across registers
    wr(3'd5, 8'hAB);
    wr(3'd2, 8'hCD);
    rd16(3'd2, v); chk("R4 shared staging", v, 16'hABCD);

    // R3 snapshot of high byte on low read
    wr16(3'd2, 16'h12FE);
    rd(3'd2, b); chk("R3 low byte", b, 8'hFE);
    ticks(5);
    rd(3'd3, b); chk("R3 latched high", b, 8'h12);
    rd16(3'd2, v); chk("R3 counter moved", v, 16'h1303);

    // R5 wrap in free-running mode
    wr(3'd0, 8'h00);
    wr16(3'd4, 16'h1234);
    wr16(3'd6, 16'h1234);
    wr16(3'd2, 16'hFFFE);
    ticks(3);
    rd16(3'd2, v); chk("R5 wrap", v, 16'h0001);

    // R12 suppressed match after counter write, both channels
    wr(3'd0, cfgByte(2'b01, 2'b11, 2'b00, 1'b0, 1'b0));
    wr16(3'd4, 16'h0010);
    wr16(3'd6, 16'h0010);
    wr16(3'd2, 16'h0010);
    ticks(1);
    chk("R12 blocked flags", {flagA, flagB}, 0);
    chk("R12 blocked pins", {ocA, ocB}, 0);
    wr16(3'd2, 16'h000F);
    ticks(2);
    chk("R7 flags set on match", {flagA, flagB}, 2'b11);
    chk("R8 toggle A set B", {ocA, ocB}, 2'b11);
    wr(3'd1, 8'h03);
    chk("R7 flags cleared", {flagA, flagB}, 0);

    // R8 clear, set, disconnect
    wr(3'd0, cfgByte(2'b10, 2'b10, 2'b00, 1'b0, 1'b0));
    wr16(3'd2, 16'h000F);
    ticks(2);
    chk("R8 clear action", {ocA, ocB}, 0);
    wr(3'd0, cfgByte(2'b11, 2'b11, 2'b00, 1'b0, 1'b0));
    wr16(3'd2, 16'h000F);
    ticks(2);
    chk("R8 set action", {ocA, ocB}, 2'b11);
    wr(3'd0, 8'h00);
    chk("R8 disconnected pins low", {ocA, ocB}, 0);
    wr(3'd0, cfgByte(2'b11, 2'b11, 2'b00, 1'b0, 1'b0));
    chk("R8 state held", {ocA, ocB}, 2'b11);

    // R9 force in clear-on-match mode, counter at top
    wr(3'd1, 8'h03);
    wr(3'd0, cfgByte(2'b01, 2'b01, 2'b01, 1'b0, 1'b0));
    wr16(3'd2, 16'h0010);
    wr(3'd1, 8'hC0);
    chk("R9 forced toggle", {ocA, ocB}, 0);
    chk("R9 no flag", {flagA, flagB}, 0);
    rd16(3'd2, v); chk("R9 counter kept", v, 16'h0010);
    rd(3'd1, b); chk("R11 force bits read zero", b, 0);

    // R10 force ignored in pulse-width codes
    wr(3'd0, cfgByte(2'b01, 2'b01, 2'b10, 1'b0, 1'b0));
    wr(3'd1, 8'hC0);
    chk("R10 force ignored 10", {ocA, ocB}, 0);
    wr(3'd0, cfgByte(2'b01, 2'b01, 2'b11, 1'b0, 1'b0));
    wr(3'd1, 8'hC0);
    chk("R10 force ignored 11", {ocA, ocB}, 0);

    // R6 clear-on-match period
    wr(3'd0, cfgByte(2'b00, 2'b00, 2'b01, 1'b0, 1'b0));
    wr16(3'd4, 16'h0004);
    wr16(3'd2, 16'h0000);
    ticks(5);
    rd16(3'd2, v); chk("R6 cleared at top", v, 0);
    chk("R6 flag A at top", flagA, 1);
    ticks(1);
    rd16(3'd2, v); chk("R6 restart", v, 1);
    rd(3'd1, b); chk("R11 flag readback", b, 8'h01);

    // R13 external pin counting
    wr(3'd0, cfgByte(2'b00, 2'b00, 2'b00, 1'b1, 1'b1));
    wr16(3'd4, 16'h1234);
    wr16(3'd2, 16'h0000);
    @(negedge clk); tickEn = 1'b1;
    repeat (6) @(negedge clk);
    pulsePin(3);
    tickEn = 1'b0;
    rd16(3'd2, v); chk("R13 rising edges", v, 3);
    wr(3'd0, cfgByte(2'b00, 2'b00, 2'b00, 1'b1, 1'b0));
    pulsePin(2);
    rd16(3'd2, v); chk("R13 falling edges", v, 5);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule